// File: doc/BRIEF.md
# Frame Queue Scheduling State Controller

This block keeps the scheduling state of a small set of frame queues on behalf of a dequeue scheduler. For each queue it holds a frame occupancy count, a flow-control flag (flow-on or flow-off) and one of three scheduling states: parked, tentative or truly scheduled. Only truly scheduled queues can be chosen for dequeue.

Three ports drive it. An enqueue strobe raises the occupancy of one queue. A management command port takes an 8-bit code and a queue index and returns a result byte. The codes are schedule, force-promote, flow-on and flow-off. A pull-dequeue strobe picks the lowest-indexed truly scheduled queue and reports its index and whether a frame was actually present.

A queue can be selected while it delivers no frame. This happens when an empty queue was force-promoted, or when flow-off was applied after the queue had already become truly scheduled. In both cases the dequeue result shows that no frame is present, and the queue falls back to tentative.

Top module: `fq_sched_ctrl`

## Requirements
- R1: After reset every queue is parked, empty and in flow-on, no strobe output is high, and a dequeue request returns "nothing selected" (hit 0, index 0, frame 0).
- R2: A response is valid in exactly the cycle after a command is accepted, as a single-cycle strobe. Codes 0x48, 0x49, 0x4D and 0x4E with an index below the queue count return 0xF0.
- R3: An unknown code or an index at or above the queue count returns 0x0F and changes no queue state.
- R4: Code 0x48 on a parked queue moves it to tentative, or straight to truly scheduled when it is non-empty and in flow-on. On a queue that is not parked it changes nothing. The state encoding is 00 parked, 01 tentative, 10 truly scheduled.
- R5: Code 0x49 promotes a tentative queue to truly scheduled whatever its occupancy or flow flag. On a parked queue it changes nothing.
- R6: An enqueue raises occupancy by one, saturating at 2^OCC_W-1, whatever the flow flag. An enqueue to a tentative queue in flow-on promotes it to truly scheduled. A parked queue stays parked.
- R7: Code 0x4D sets flow-on. A tentative queue that holds frames then becomes truly scheduled.
- R8: Code 0x4E sets flow-off. A tentative queue then stays tentative however many frames arrive. A queue that is already truly scheduled stays selectable, but its dequeue carries no frame.
- R9: A dequeue result is valid in the cycle after the request. It selects the lowest-indexed truly scheduled queue, never a parked or tentative one.
- R10: A frame is present when the selected queue is non-empty and in flow-on. Occupancy then drops by one, and the queue returns to tentative when it reaches zero. When no frame is present, occupancy is unchanged and the queue returns to tentative.
- R11: When several operations hit one queue in the same cycle, they apply in the order dequeue, then enqueue, then command. Selection uses the state held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Management command strobe |
| cmd_code | input | 8 | Command code |
| cmd_idx | input | CIDX_W | Target queue index (may be out of range) |
| rsp_valid | output | 1 | Result strobe, one cycle after the command |
| rsp_code | output | 8 | Result code (0xF0 ok, 0x0F error) |
| enq_valid | input | 1 | Enqueue strobe |
| enq_idx | input | IDX_W | Enqueue target queue |
| deq_req | input | 1 | Pull-dequeue request |
| deq_valid | output | 1 | Dequeue result strobe |
| deq_hit | output | 1 | A queue was selected |
| deq_idx | output | IDX_W | Selected queue index |
| deq_frame | output | 1 | Selected queue delivered a frame |

## Verification
Both results are registered once. The command result and the dequeue result are therefore due one clock after the strobe that caused them, and an enqueue shows up only through the next dequeue it affects. The driver records the due cycle with every expected item it pushes. The monitor pops an item only in that cycle and flags a strobe that arrives early, late or with no item waiting. Effects that are invisible at the ports, such as a queue staying parked or tentative or an ignored command, are proven by the dequeue that follows and by the dequeue result it must give.

// File: rtl/fq_sched_ctrl.sv
module fq_sched_ctrl #(
  parameter int NQ     = 8,
  parameter int OCC_W  = 8,
  parameter int IDX_W  = $clog2(NQ),
  parameter int CIDX_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [CIDX_W-1:0] cmd_idx,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  input  logic              enq_valid,
  input  logic [IDX_W-1:0]  enq_idx,
  input  logic              deq_req,
  output logic              deq_valid,
  output logic              deq_hit,
  output logic [IDX_W-1:0]  deq_idx,
  output logic              deq_frame
);

  localparam logic [1:0] ST_PARK = 2'b00;
  localparam logic [1:0] ST_TENT = 2'b01;
  localparam logic [1:0] ST_TRUE = 2'b10;
  localparam logic [7:0] OP_SCHED = 8'h48;
  localparam logic [7:0] OP_FORCE = 8'h49;
  localparam logic [7:0] OP_FON   = 8'h4D;
  localparam logic [7:0] OP_FOFF  = 8'h4E;
  localparam logic [7:0] RC_OK    = 8'hF0;
  localparam logic [7:0] RC_ERR   = 8'h0F;
  localparam logic [OCC_W-1:0] OCC_MAX = '1;

  logic [NQ-1:0][1:0]       st_q, st_d;
  logic [NQ-1:0][OCC_W-1:0] occ_q, occ_d;
  logic [NQ-1:0]            off_q, off_d;

  logic             idx_ok, code_ok, cmd_ok;
  logic             sel_any, sel_frame;
  logic [IDX_W-1:0] sel_idx;

  assign idx_ok  = cmd_idx < CIDX_W'(NQ);
  assign code_ok = (cmd_code == OP_SCHED) || (cmd_code == OP_FORCE) ||
                   (cmd_code == OP_FON)   || (cmd_code == OP_FOFF);
  assign cmd_ok  = cmd_valid && idx_ok && code_ok;

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (st_q[i] == ST_TRUE) begin
        sel_any = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign sel_frame = sel_any && (occ_q[sel_idx] != '0) && !off_q[sel_idx];

  always_comb begin
    st_d  = st_q;
    occ_d = occ_q;
    off_d = off_q;
    for (int i = 0; i < NQ; i++) begin
      if (deq_req && sel_any && sel_idx == IDX_W'(i)) begin
        if (sel_frame) begin
          occ_d[i] = occ_q[i] - 1'b1;
          if (occ_q[i] == OCC_W'(1)) st_d[i] = ST_TENT;
        end else begin
          st_d[i] = ST_TENT;
        end
      end
      if (enq_valid && enq_idx == IDX_W'(i)) begin
        if (occ_d[i] != OCC_MAX) occ_d[i] = occ_d[i] + 1'b1;
        if (st_d[i] == ST_TENT && !off_d[i]) st_d[i] = ST_TRUE;
      end
      if (cmd_ok && cmd_idx == CIDX_W'(i)) begin
        unique case (cmd_code)
          OP_SCHED: if (st_d[i] == ST_PARK)
                      st_d[i] = (occ_d[i] != '0 && !off_d[i]) ? ST_TRUE : ST_TENT;
          OP_FORCE: if (st_d[i] == ST_TENT) st_d[i] = ST_TRUE;
          OP_FON: begin
            off_d[i] = 1'b0;
            if (st_d[i] == ST_TENT && occ_d[i] != '0) st_d[i] = ST_TRUE;
          end
          OP_FOFF:  off_d[i] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      occ_q     <= '0;
      off_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      deq_valid <= 1'b0;
      deq_hit   <= 1'b0;
      deq_idx   <= '0;
      deq_frame <= 1'b0;
    end else begin
      st_q      <= st_d;
      occ_q     <= occ_d;
      off_q     <= off_d;
      rsp_valid <= cmd_valid;
      rsp_code  <= cmd_valid ? (cmd_ok ? RC_OK : RC_ERR) : 8'h00;
      deq_valid <= deq_req;
      deq_hit   <= deq_req && sel_any;
      deq_idx   <= deq_req ? sel_idx : '0;
      deq_frame <= deq_req && sel_frame;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid); // R2
  AST_BAD_IDX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_idx >= CIDX_W'(NQ)) |=> rsp_code != RC_OK); // R3
  AST_BAD_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_idx >= CIDX_W'(NQ)) && !enq_valid && !deq_req
    |=> $stable(st_q) && $stable(off_q) && $stable(occ_q)); // R3
  AST_DEQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req |=> deq_valid); // R9
  AST_FRAME_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && deq_frame |-> deq_hit); // R10
  AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req && sel_any && off_q[sel_idx] |=> !deq_frame); // R8

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] != 2'b11); // R4
  end

endmodule

// File: tb/test_fq_sched_ctrl.sv
module test_fq_sched_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [3:0] cmd_idx = '0;
  logic       enq_valid = 1'b0;
  logic [2:0] enq_idx = '0;
  logic       deq_req = 1'b0;
  logic       rsp_valid, deq_valid, deq_hit, deq_frame;
  logic [7:0] rsp_code;
  logic [2:0] deq_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { int due; logic [7:0] code; string tag; } rsp_t;
  typedef struct { int due; logic hit; logic [2:0] idx; logic frame; string tag; } deq_t;
  rsp_t rq[$];
  deq_t dq[$];

  fq_sched_ctrl i_fq_sched_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_idx(cmd_idx),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .enq_valid(enq_valid), .enq_idx(enq_idx),
    .deq_req(deq_req), .deq_valid(deq_valid), .deq_hit(deq_hit),
    .deq_idx(deq_idx), .deq_frame(deq_frame)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rq.size() > 0 && rq[0].due == cyc) begin
        checks++;
        if (!rsp_valid || rsp_code !== rq[0].code) begin
          errors++;
          $display("FAIL %s rsp valid=%0b code=%02h expected valid=1 code=%02h",
                   rq[0].tag, rsp_valid, rsp_code, rq[0].code);
        end
        void'(rq.pop_front());
      end else if (rsp_valid) begin
        errors++;
        $display("FAIL R2 unexpected rsp code=%02h expected no strobe", rsp_code);
      end
      if (dq.size() > 0 && dq[0].due == cyc) begin
        checks++;
        if (!deq_valid || deq_hit !== dq[0].hit || deq_idx !== dq[0].idx ||
            deq_frame !== dq[0].frame) begin
          errors++;
          $display("FAIL %s deq v=%0b hit=%0b idx=%0d frame=%0b expected v=1 hit=%0b idx=%0d frame=%0b",
                   dq[0].tag, deq_valid, deq_hit, deq_idx, deq_frame,
                   dq[0].hit, dq[0].idx, dq[0].frame);
        end
        void'(dq.pop_front());
      end else if (deq_valid) begin
        errors++;
        $display("FAIL R9 unexpected deq strobe idx=%0d expected no strobe", deq_idx);
      end
    end
  end

  task automatic drive(bit e, int ei, bit c, int cc, int ci, bit d);
    enq_valid = e; enq_idx = ei[2:0];
    cmd_valid = c; cmd_code = cc[7:0]; cmd_idx = ci[3:0];
    deq_req = d;
    @(negedge clk);
    enq_valid = 0; cmd_valid = 0; deq_req = 0;
  endtask

  task automatic exp_rsp(logic [7:0] code, string tag);
    rsp_t r; r.due = cyc + 1; r.code = code; r.tag = tag; rq.push_back(r);
  endtask

  task automatic exp_deq(logic hit, int idx, logic frame, string tag);
    deq_t x; x.due = cyc + 1; x.hit = hit; x.idx = idx[2:0]; x.frame = frame; x.tag = tag;
    dq.push_back(x);
  endtask

  task automatic cmd(int cc, int ci, logic [7:0] code, string tag);
    exp_rsp(code, tag); drive(0, 0, 1, cc, ci, 0);
  endtask

  task automatic enq(int i);
    drive(1, i, 0, 0, 0, 0);
  endtask

  task automatic deq(logic hit, int idx, logic frame, string tag);
    exp_deq(hit, idx, frame, tag); drive(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || deq_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_valid=%0b deq_valid=%0b expected 0 0", rsp_valid, deq_valid);
    end
    deq(0, 0, 0, "R1 reset no selection");

    enq(2); enq(2);
    deq(0, 0, 0, "R6 parked stays parked");
    cmd(8'h48, 2, 8'hF0, "R2 schedule ok");
    deq(1, 2, 1, "R4 schedule non-empty to true");
    deq(1, 2, 1, "R10 last frame");
    deq(0, 0, 0, "R10 empty returns tentative");

    cmd(8'h48, 5, 8'hF0, "R4 schedule empty");
    deq(0, 0, 0, "R4 empty stays tentative");
    cmd(8'h49, 5, 8'hF0, "R5 force ok");
    deq(1, 5, 0, "R5 forced empty no frame");
    deq(0, 0, 0, "R10 no-frame returns tentative");

    enq(5);
    cmd(8'h48, 1, 8'hF0, "R4 schedule q1");
    enq(1);
    deq(1, 1, 1, "R9 lowest index first");
    deq(1, 5, 1, "R6 enqueue promotes tentative");
    deq(0, 0, 0, "R9 none left");

    cmd(8'h48, 3, 8'hF0, "R4 schedule q3");
    cmd(8'h4E, 3, 8'hF0, "R8 flow-off ok");
    enq(3); enq(3);
    deq(0, 0, 0, "R8 flow-off stays tentative");
    cmd(8'h4D, 3, 8'hF0, "R7 flow-on ok");
    deq(1, 3, 1, "R7 flow-on promotes");
    cmd(8'h4E, 3, 8'hF0, "R8 late flow-off");
    deq(1, 3, 0, "R8 late flow-off no frame");
    deq(0, 0, 0, "R8 back to tentative");
    cmd(8'h4D, 3, 8'hF0, "R7 flow-on again");
    deq(1, 3, 1, "R10 occupancy kept");
    deq(0, 0, 0, "R10 drained");

    cmd(8'h50, 4, 8'h0F, "R3 unknown code");
    cmd(8'h48, 8, 8'h0F, "R3 index out of range");
    cmd(8'h49, 6, 8'hF0, "R5 force on parked");
    enq(0); enq(4); enq(6);
    deq(0, 0, 0, "R3 R5 no state changed");
    cmd(8'h48, 0, 8'hF0, "R4 schedule q0");
    deq(1, 0, 1, "R3 q0 was parked");
    cmd(8'h48, 4, 8'hF0, "R4 schedule q4");
    deq(1, 4, 1, "R3 q4 was parked");
    cmd(8'h48, 6, 8'hF0, "R4 schedule q6");
    deq(1, 6, 1, "R5 q6 was parked");

    exp_rsp(8'hF0, "R11 flow-off same cycle");
    drive(1, 2, 1, 8'h4E, 2, 0);
    deq(1, 2, 0, "R11 enqueue before flow-off");
    cmd(8'h4D, 2, 8'hF0, "R7 flow-on q2");
    deq(1, 2, 1, "R11 frame kept");

    for (int k = 0; k < 256; k++) enq(7);
    cmd(8'h48, 7, 8'hF0, "R6 schedule full queue");
    for (int k = 0; k < 255; k++) deq(1, 7, 1, "R6 saturated drain");
    deq(0, 0, 0, "R6 saturation at max");

    repeat (3) @(negedge clk);
    checks++;
    if (rq.size() != 0 || dq.size() != 0) begin
      errors++;
      $display("FAIL R2 pending rsp=%0d deq=%0d expected 0 0", rq.size(), dq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule